// File: doc/BRIEF.md
# Page Write Buffer and Program Controller

This block sits behind the serial protocol engine of a byte-addressed nonvolatile memory. During a write command it gathers the incoming data bytes into a 64-byte row latch. Each latched byte gets a valid flag. If the command ends in the one slot where ending is allowed, the block runs a self-timed program cycle. That cycle first waits a fixed lock-out time. It then copies the flagged bytes of the latch into the memory array, one column per clock. While the cycle runs, the block ignores every event from the protocol engine.

The protocol engine supplies single-cycle event pulses, all synchronous to the system clock. These cover START, STOP, end of the address phase, a received data byte, the end of a data acknowledge, and any later bit on the bus. It also supplies the level of the write-protect pin. The array is a synchronous RAM inside the block. It reads as FFh until a location is programmed, and it has a read port so that stored contents can be inspected.

The write time is a parameter counted in system-clock cycles, so that a simulation can use a short value.

Top module: `rp_page_writer`

## Requirements
- R1: At `addr_load`, `addr_in[ADDR_W-1:6]` selects the row and `addr_in[5:0]` the starting column. Every data byte of the command is stored in that row.
- R2: After each accepted `data_stb`, only the 6-bit column advances, wrapping from 63 to 0. A later byte at the same column replaces the earlier one, so the last byte written to a column wins.
- R3: A program cycle starts only on a `stop_evt` that arrives while armed. A `dack_evt` after at least one latched byte arms the block. `bit_evt`, `start_evt` and `addr_load` disarm it. Any other STOP discards the latch and leaves the array unchanged.
- R4: `busy` rises on the cycle after the accepted STOP. It stays high for exactly TWR_CYC + 64 cycles: the timed lock-out, then one write slot per column.
- R5: While `busy` is high, no input event has any effect. This covers `start_evt`, `addr_load`, `data_stb`, `dack_evt`, `bit_evt` and `stop_evt`.
- R6: If `wp` is high on any cycle from `start_evt` up to and including `addr_load`, no byte is latched and no program cycle starts.
- R7: After reset every array location reads FFh. `rd_data` returns the byte at `rd_addr` one cycle after it is presented.
- R8: Only flagged columns take new data, and the others keep their old contents. In a row that has never been programmed, the block writes FFh to the unflagged columns. `wr_en` is never high while `busy` is low.
- R9: `start_evt` and `addr_load` both clear every valid flag. Bytes latched before them are never programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | START seen on the bus (pulse) |
| stop_evt | input | 1 | STOP seen on the bus (pulse) |
| bit_evt | input | 1 | A bus bit sampled after a data acknowledge (pulse) |
| dack_evt | input | 1 | Acknowledge slot of a data byte has ended (pulse) |
| wp | input | 1 | Write-protect level |
| addr_load | input | 1 | Two-byte address phase complete (pulse) |
| addr_in | input | ADDR_W | Byte address captured at `addr_load` |
| data_stb | input | 1 | A data byte has been received (pulse) |
| data_in | input | 8 | Received data byte |
| busy | output | 1 | Program cycle in progress |
| wr_en | output | 1 | Array write enable |
| wr_addr | output | ADDR_W | Array write address |
| wr_data | output | 8 | Array write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data, one cycle latency |

## Verification
The assertions check four properties on every cycle. A STOP that is unarmed or protected never raises `busy`. The row held in the latch cannot move while `busy` is high. The column steps by one, modulo 64, on each accepted byte. Every `busy` window lasts exactly TWR_CYC + 64 cycles and never writes outside it.

Some behaviours only the bench scenarios can show, because they require reading the array back after the cycle. These are the wrap-and-overwrite result, the preservation of untouched columns in a previously programmed row, and the erased contents after reset. The same applies to showing that events injected during the lock-out leave the stored row as the earlier command left it.

// File: rtl/rp_pkg.sv
package rp_pkg;
    localparam int BYTE_W    = 8;
    localparam int COL_W     = 6;
    localparam int ROW_BYTES = 1 << COL_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [COL_W-1:0]  col_t;

    localparam byte_t ERASED = 8'hFF;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_SCAN
    } sq_state_t;

    typedef struct packed {
        logic  vld;
        byte_t dat;
    } row_slot_t;

    function automatic col_t col_step(col_t c);
        return c + col_t'(1);
    endfunction
endpackage

// File: rtl/rp_latch.sv
module rp_latch
    import rp_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic                    put,
    input  byte_t                   din,
    input  col_t                    rd_col,
    output logic [ADDR_W-COL_W-1:0] row,
    output row_slot_t               rd_slot,
    output logic                    any_vld
);
    col_t      col;
    row_slot_t slot [ROW_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0;
            row <= '0;
            for (int i = 0; i < ROW_BYTES; i++) slot[i] <= '{vld: 1'b0, dat: ERASED};
        end else begin
            if (load) begin
                row <= addr_in[ADDR_W-1:COL_W];
                col <= addr_in[COL_W-1:0];
            end else if (put) begin
                col <= col_step(col);
            end
            if (clr) begin
                for (int i = 0; i < ROW_BYTES; i++) slot[i].vld <= 1'b0;
            end else if (put) begin
                slot[col] <= '{vld: 1'b1, dat: din};
            end
        end
    end

    always_comb begin
        any_vld = 1'b0;
        for (int i = 0; i < ROW_BYTES; i++) any_vld |= slot[i].vld;
    end

    assign rd_slot = slot[rd_col];

    AST_COL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (put && !load) |=> col == col_step($past(col)));  // R2
    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        clr |=> !any_vld);  // R9
endmodule

// File: rtl/rp_seq.sv
module rp_seq
    import rp_pkg::*;
#(
    parameter int TWR_CYC = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic fresh_in,
    output logic busy,
    output logic scan,
    output col_t scol,
    output logic fresh_q
);
    localparam int TMR_W = $clog2(TWR_CYC + 1);

    sq_state_t        st;
    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            tmr     <= '0;
            scol    <= '0;
            fresh_q <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: if (go) begin
                    st      <= SQ_WAIT;
                    tmr     <= '0;
                    fresh_q <= fresh_in;
                end
                SQ_WAIT: if (tmr == TMR_W'(TWR_CYC - 1)) begin
                    st   <= SQ_SCAN;
                    scol <= '0;
                end else begin
                    tmr <= tmr + TMR_W'(1);
                end
                SQ_SCAN: begin
                    scol <= col_step(scol);
                    if (scol == col_t'(ROW_BYTES - 1)) st <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy = (st != SQ_IDLE);
    assign scan = (st == SQ_SCAN);

    int blen;
    always_ff @(posedge clk) begin
        if (rst)       blen <= 0;
        else if (busy) blen <= blen + 1;
        else           blen <= 0;
    end

    AST_GO_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (go && !busy) |=> busy);  // R4
    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> blen == TWR_CYC + ROW_BYTES);  // R4
endmodule

// File: rtl/rp_array.sv
module rp_array
    import rp_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  byte_t                   wdat,
    input  logic [ADDR_W-1:0]       raddr,
    output byte_t                   rdat,
    input  logic [ADDR_W-COL_W-1:0] qrow,
    output logic                    qfresh
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int ROWS  = 1 << (ADDR_W - COL_W);

    byte_t           mem [DEPTH];
    logic [ROWS-1:0] used;

    always_ff @(posedge clk) begin
        if (rst) begin
            used <= '0;
            rdat <= ERASED;
        end else begin
            if (we) used[waddr[ADDR_W-1:COL_W]] <= 1'b1;
            rdat <= used[raddr[ADDR_W-1:COL_W]] ? mem[raddr] : ERASED;
        end
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdat;
    end

    assign qfresh = !used[qrow];
endmodule

// File: rtl/rp_page_writer.sv
module rp_page_writer
    import rp_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int TWR_CYC = 1_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              bit_evt,
    input  logic              dack_evt,
    input  logic              wp,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_stb,
    input  logic [7:0]        data_in,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int ROW_W = ADDR_W - COL_W;

    logic             addr_ok, prot, wp_seen, armed;
    logic             put, clr, go;
    logic [ROW_W-1:0] lat_row;
    row_slot_t        cur_slot;
    logic             any_vld, scan, fresh_now, fresh_q;
    col_t             scol;

    assign put = !busy && data_stb && addr_ok && !prot;
    assign go  = !busy && stop_evt && armed;
    assign clr = !busy && (start_evt || addr_load || (stop_evt && !armed));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_ok <= 1'b0;
            prot    <= 1'b0;
            wp_seen <= 1'b0;
            armed   <= 1'b0;
        end else if (!busy) begin
            if (start_evt) begin
                wp_seen <= wp;
                addr_ok <= 1'b0;
                prot    <= 1'b0;
                armed   <= 1'b0;
            end else if (addr_load) begin
                prot    <= wp_seen | wp;
                addr_ok <= 1'b1;
                armed   <= 1'b0;
            end else begin
                if (!addr_ok) wp_seen <= wp_seen | wp;
                if (stop_evt) begin
                    addr_ok <= 1'b0;
                    armed   <= 1'b0;
                end else if (bit_evt) begin
                    armed <= 1'b0;
                end else if (dack_evt && addr_ok && !prot && any_vld) begin
                    armed <= 1'b1;
                end
            end
        end
    end

    rp_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst(rst), .clr(clr), .load(addr_load && !busy),
        .addr_in(addr_in), .put(put), .din(data_in), .rd_col(scol),
        .row(lat_row), .rd_slot(cur_slot), .any_vld(any_vld)
    );

    rp_seq #(.TWR_CYC(TWR_CYC)) u_seq (
        .clk(clk), .rst(rst), .go(go), .fresh_in(fresh_now),
        .busy(busy), .scan(scan), .scol(scol), .fresh_q(fresh_q)
    );

    assign wr_en   = scan && (cur_slot.vld || fresh_q);
    assign wr_addr = {lat_row, scol};
    assign wr_data = cur_slot.vld ? cur_slot.dat : ERASED;

    rp_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdat(wr_data),
        .raddr(rd_addr), .rdat(rd_data), .qrow(lat_row), .qfresh(fresh_now)
    );

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !wr_en);  // R8
    AST_UNARMED_STOP: assert property (@(posedge clk) disable iff (rst)
        (stop_evt && !armed && !busy) |=> !busy);  // R3
    AST_PROT_NO_PROG: assert property (@(posedge clk) disable iff (rst)
        (stop_evt && addr_ok && prot && !busy) |=> !busy);  // R6
    AST_ROW_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(lat_row));  // R5
endmodule

// File: tb/rp_page_writer_test.sv
module rp_page_writer_test;
    localparam int AW     = 12;
    localparam int TB_TWR = 20;
    localparam int BUSY_N = TB_TWR + 64;

    typedef struct packed {
        logic [11:0] a;
        logic [7:0]  n;
        logic [7:0]  s;
        logic        w;
        logic        g;
    } vec_t;

    // start address, byte count, data seed, wp at START, clean STOP
    localparam vec_t VEC [7] = '{
        '{a: 12'h040, n: 8'd1,  s: 8'hA5, w: 1'b0, g: 1'b1},  // R1 byte write
        '{a: 12'h0BC, n: 8'd8,  s: 8'h10, w: 1'b0, g: 1'b1},  // R2 wrap
        '{a: 12'h0C5, n: 8'd70, s: 8'h33, w: 1'b0, g: 1'b1},  // R2 overwrite
        '{a: 12'h105, n: 8'd4,  s: 8'h5A, w: 1'b1, g: 1'b1},  // R6 protected
        '{a: 12'h140, n: 8'd3,  s: 8'h66, w: 1'b0, g: 1'b0},  // R3 late STOP
        '{a: 12'h04A, n: 8'd2,  s: 8'h77, w: 1'b0, g: 1'b1},  // R8 keep old
        '{a: 12'hFC0, n: 8'd64, s: 8'h01, w: 1'b0, g: 1'b1}   // R1 full row
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_evt = 0, stop_evt = 0, bit_evt = 0, dack_evt = 0;
    logic          wp = 0, addr_load = 0, data_stb = 0;
    logic [AW-1:0] addr_in = '0, rd_addr = '0;
    logic [7:0]    data_in = '0;
    logic          busy, wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data, rd_data;

    int   checks = 0, errors = 0;
    bit   done = 0;
    logic [7:0] model [1 << AW];

    always #2.5 clk = ~clk;

    rp_page_writer #(.ADDR_W(AW), .TWR_CYC(TB_TWR)) uut (
        .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
        .bit_evt(bit_evt), .dack_evt(dack_evt), .wp(wp), .addr_load(addr_load),
        .addr_in(addr_in), .data_stb(data_stb), .data_in(data_in), .busy(busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(bit w);
        @(negedge clk); start_evt = 1; wp = w;
        @(negedge clk); start_evt = 0;
    endtask
    task automatic pulse_addr(logic [AW-1:0] a);
        @(negedge clk); addr_load = 1; addr_in = a; wp = 0;
        @(negedge clk); addr_load = 0;
    endtask
    task automatic send_byte(logic [7:0] d);
        @(negedge clk); data_stb = 1; data_in = d;
        @(negedge clk); data_stb = 0; dack_evt = 1;
        @(negedge clk); dack_evt = 0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); stop_evt = 1;
        @(negedge clk); stop_evt = 0;
    endtask

    // counts busy samples; with inject, drives events mid-cycle
    task automatic count_busy(bit inject, output int cnt);
        cnt = 0;
        for (int i = 0; busy && i < 1000; i++) begin
            cnt++;
            start_evt = inject && i == 2;
            addr_load = inject && i == 3;
            addr_in   = 12'h200;
            data_stb  = inject && i == 4;
            data_in   = 8'hEE;
            dack_evt  = inject && i == 5;
            stop_evt  = inject && i == 6;
            bit_evt   = inject && i == 7;
            @(negedge clk);
        end
        {start_evt, addr_load, data_stb, dack_evt, stop_evt, bit_evt} = '0;
    endtask

    task automatic check_row(logic [5:0] row, string req);
        int   bad = -1;
        logic [7:0] got = '0;
        for (int c = 0; c < 64; c++) begin
            rd_addr = {row, 6'(c)};
            @(negedge clk);
            if (bad < 0 && rd_data !== model[{row, 6'(c)}]) begin
                bad = c;
                got = rd_data;
            end
        end
        if (bad < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, got, model[{row, 6'(bad)}]);
    endtask

    task automatic run_write(vec_t v, bit inject, string req);
        logic [5:0] col = v.a[5:0];
        int cnt;
        pulse_start(v.w);
        pulse_addr(v.a);
        for (int k = 0; k < int'(v.n); k++) begin
            logic [7:0] d = v.s + 8'(k * 7);
            send_byte(d);
            if (!v.w && v.g) model[{v.a[11:6], col}] = d;
            col = col + 6'd1;
        end
        if (!v.g) begin
            @(negedge clk); bit_evt = 1;
            @(negedge clk); bit_evt = 0;
        end
        pulse_stop();
        count_busy(inject, cnt);
        check(cnt == ((!v.w && v.g) ? BUSY_N : 0), {req, " busy span R4"},
              cnt, (!v.w && v.g) ? BUSY_N : 0);
        check_row(v.a[11:6], req);
    endtask

    initial begin
        int cnt;
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(busy == 0, "R4 busy low after reset", busy, 0);
        check(wr_en == 0, "R8 no write after reset", wr_en, 0);
        rd_addr = 12'h000; @(negedge clk);
        check(rd_data == 8'hFF, "R7 erased at 000", rd_data, 8'hFF);
        rd_addr = 12'hFFF; @(negedge clk);
        check(rd_data == 8'hFF, "R7 erased at FFF", rd_data, 8'hFF);

        for (int v = 0; v < 7; v++) run_write(VEC[v], 1'b0, "R1 R2 R3 R6 R8 vector row");

        // R5: events during busy have no effect
        run_write('{a: 12'h200, n: 8'd2, s: 8'hC0, w: 1'b0, g: 1'b1}, 1'b1, "R5 events ignored");
        pulse_stop();
        check(busy == 0, "R3 lone STOP after program", busy, 0);

        // R9: START and address reload drop earlier bytes
        pulse_start(0);
        pulse_addr(12'h300);
        send_byte(8'hAA);
        pulse_start(0);
        pulse_addr(12'h305);
        send_byte(8'h5B);
        model[12'h305] = 8'h5B;
        pulse_stop();
        count_busy(1'b0, cnt);
        check(cnt == BUSY_N, "R9 busy span", cnt, BUSY_N);
        check_row(6'h0C, "R9 only last command programmed");

        // R6: wp high only between START and address end
        pulse_start(0);
        @(negedge clk); wp = 1;
        @(negedge clk); wp = 0;
        pulse_addr(12'h340);
        send_byte(8'h11);
        pulse_stop();
        check(busy == 0, "R6 protect in address phase", busy, 0);
        check_row(6'h0D, "R6 row untouched");
        check(wr_en == 0, "R8 idle no write", wr_en, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule